// File: doc/BRIEF.md
# Flash Controller Interrupt and Command Gate

This block is the register-level control core of a memory-mapped flash controller. It holds the command register, the error status register, the interrupt status register, two configuration registers and the start-buffer register, all reached over a simple 16-bit register bus with a one-cycle write strobe and a combinational read path. Accepted commands are handed to an external command executor as a one-cycle start pulse carrying the command code. The executor reports back with a done pulse that names the kind of operation that finished and whether it failed.

Software works in a fixed cycle. It writes a command, waits for the interrupt, reads the status, and then acknowledges the interrupt by writing zeros into the interrupt status register. While the master interrupt flag is pending, every new command is refused. Acknowledging the master flag also wipes the error flags. The interrupt pin's active level is selected by a configuration bit. A ready pin reflects a configuration bit, and the start-buffer register is decoded into a buffer selector and a sector count.

Top module: `flash_ctl_core`

## Requirements
- R1: A cold reset (synchronous, `rst_n` low at a clock edge) sets the registers as follows: configuration-1 to 0x40C0, configuration-2 to 0, status to 0, interrupt status to 0x8080, command to 0 and start-buffer readback to 0x0001. It also drives `rdy` to 1 and `irq` to 1.
- R2: `irq` is interrupt-status bit 15 XNOR configuration-1 bit 6. With bit 6 at 1 the pin is active high, and with bit 6 at 0 it is active low.
- R3: A write to the command register (offset 0x0) while interrupt-status bit 15 is set is dropped. The command register keeps its value, no `cmd_start` pulse follows and no flag changes.
- R4: An accepted write of a recognised command loads the command register. In the cycle after the write it produces a one-cycle `cmd_start` with `cmd_code` equal to the written value. The recognised command codes are 0x00, 0x13, 0x80, 0x1A, 0x1B, 0x23, 0x27, 0x2A, 0x2C, 0x30, 0x65, 0x71, 0x94, 0x95 and 0xB0.
- R5: An accepted write of any other code, apart from 0xF0 and 0xF3, loads the command register. It sets status bit 10 (command error) and interrupt-status bit 15, and produces no `cmd_start`.
- R6: A write to the interrupt status register (offset 0x5) ANDs the written value into it. If bit 15 of the result is 0, status bits 10 to 13 are all cleared.
- R7: A `done_valid` pulse sets interrupt-status bit 15 together with the bit for its `done_op`: 0 selects reset (bit 4), 1 selects erase (bit 5), 2 selects program (bit 6) and 3 selects load (bit 7).
- R8: When `done_fail` is high with `done_valid`, status bit 10 is also set, along with the operation's error bit: 11 for erase, 12 for program and 13 for load. The reset operation sets only bit 10.
- R9: When an interrupt-status write and a done pulse fall in the same cycle, the AND and the error wipe are applied first, and the done pulse's interrupt and error bits are then added.
- R10: An accepted command 0xF0 or 0xF3 performs a warm reset. It restores the R1 values except that interrupt status becomes 0x8010, and it produces no `cmd_start`.
- R11: A write to configuration-1 (offset 0x1) moves `rdy` to bit 7 of the written value. Configuration-1 reads back with bits 4:0 forced to 0. Configuration-2 (offset 0x2) reads back all 16 bits.
- R12: A start-buffer write (offset 0x8) takes bits 11:8 as `buf_sel` and bits 1:0 as the sector-count code, where code 0 means 4 sectors. The register reads back as the buffer address in bits 11:8 and the raw code in bits 1:0. The status register sits at offset 0x4 and is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low cold reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 4 | Register offset for both write and read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| done_valid | input | 1 | Executor finished an operation |
| done_op | input | 2 | Finished operation kind: 0 reset, 1 erase, 2 program, 3 load |
| done_fail | input | 1 | Finished operation failed |
| cmd_start | output | 1 | One-cycle start pulse for the executor |
| cmd_code | output | 16 | Command code carried with `cmd_start` |
| buf_sel | output | 4 | Selected data buffer |
| sec_count | output | 3 | Sector count, 1 to 4 |
| irq | output | 1 | Interrupt pin with configurable polarity |
| rdy | output | 1 | Ready pin |

## Verification
The risky coincidence is an executor done pulse that lands in the same cycle as software's acknowledge write to the interrupt status register. A lost completion there would hang the driver. A stale error would look like a failure of the next operation. The bench first leaves a load error pending. It then drives a zero write to the interrupt register together with a failing erase completion. It judges the result by reading back interrupt status 0x8020 and status 0x0C00: the old load error is gone, and the new erase interrupt and error are present.

// File: rtl/flash_ctl_pkg.sv
// Package: shared constants, operation kinds and command classification
// for the flash controller control core. Assumes 16-bit registers.
package flash_ctl_pkg;

    localparam int DATA_W = 16;

    // Register offsets on the register bus
    localparam int OFF_CMD  = 0;
    localparam int OFF_CFG1 = 1;
    localparam int OFF_CFG2 = 2;
    localparam int OFF_STAT = 4;
    localparam int OFF_INT  = 5;
    localparam int OFF_SBUF = 8;

    // Interrupt status bit positions
    localparam int INT_MASTER = 15;
    localparam int INT_RST    = 4;
    localparam int INT_ERASE  = 5;
    localparam int INT_PROG   = 6;
    localparam int INT_LOAD   = 7;

    // Error status bit positions
    localparam int ERR_CMD   = 10;
    localparam int ERR_ERASE = 11;
    localparam int ERR_PROG  = 12;
    localparam int ERR_LOAD  = 13;

    // Configuration-1 bit positions
    localparam int CFG1_POL_BIT = 6;
    localparam int CFG1_RDY_BIT = 7;

    // Reset values
    localparam logic [DATA_W-1:0] CFG1_RST    = 16'h40C0;
    localparam logic [DATA_W-1:0] CFG2_RST    = 16'h0000;
    localparam logic [DATA_W-1:0] INT_COLD    = 16'h8080;
    localparam logic [DATA_W-1:0] INT_WARM    = 16'h8010;
    localparam logic [DATA_W-1:0] CFG1_RDMASK = 16'hFFE0;
    localparam logic [DATA_W-1:0] ERR_MASK    = 16'h3C00;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_ERASE = 2'd1,
        OP_PROG  = 2'd2,
        OP_LOAD  = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        CC_UNKNOWN  = 2'd0,
        CC_DISPATCH = 2'd1,
        CC_SOFTRST  = 2'd2
    } cmd_class_e;

    // Sorts a command code into executor work, in-core reset or unknown
    function automatic cmd_class_e classify_cmd(input logic [DATA_W-1:0] code);
        cmd_class_e cls;
        case (code)
            16'h0000, 16'h0013, 16'h0080, 16'h001A, 16'h001B,
            16'h0023, 16'h0027, 16'h002A, 16'h002C, 16'h0030,
            16'h0065, 16'h0071, 16'h0094, 16'h0095, 16'h00B0:
                cls = CC_DISPATCH;
            16'h00F0, 16'h00F3:
                cls = CC_SOFTRST;
            default:
                cls = CC_UNKNOWN;
        endcase
        return cls;
    endfunction

endpackage

// File: rtl/flash_ctl_cmd_gate.sv
// Command gate: accepts a command write only when no interrupt is pending,
// holds the command register, and issues a registered start pulse to the
// executor. Unknown and reset-class commands are flagged combinationally
// in the write cycle so the other units update at the same edge.
// Assumes cmd_we is a single-cycle strobe.
module flash_ctl_cmd_gate
    import flash_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pending,
    output logic [DATA_W-1:0] cmd_q,
    output logic              cmd_start,
    output logic [DATA_W-1:0] cmd_code,
    output logic              unknown_cmd,
    output logic              soft_rst
);

    logic       accept;
    cmd_class_e cls;

    // Decide acceptance and class of the write in flight
    always_comb begin
        accept      = cmd_we && !pending;
        cls         = classify_cmd(wdata);
        unknown_cmd = accept && (cls == CC_UNKNOWN);
        soft_rst    = accept && (cls == CC_SOFTRST);
    end

    // Hold the command register and the executor start pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            cmd_start <= 1'b0;
            cmd_code  <= '0;
        end else begin
            cmd_start <= accept && (cls == CC_DISPATCH);
            if (accept) begin
                cmd_q <= (cls == CC_SOFTRST) ? '0 : wdata;
                if (cls == CC_DISPATCH) begin
                    cmd_code <= wdata;
                end
            end
        end
    end

    assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && pending) |=> $stable(cmd_q));

    assert_no_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && pending) |=> !cmd_start);

    assert_start_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> (cmd_code == cmd_q));

endmodule

// File: rtl/flash_ctl_irq.sv
// Interrupt and error status: holds the interrupt status and error status
// registers. Applies write-to-clear AND masking, wipes errors when the
// master flag drops, then merges executor completions and unknown-command
// flags. Reset classes: rst_n cold, soft_rst warm.
module flash_ctl_irq
    import flash_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              unknown_cmd,
    input  logic              int_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done_valid,
    input  logic [1:0]        done_op,
    input  logic              done_fail,
    output logic [DATA_W-1:0] int_stat,
    output logic [DATA_W-1:0] err_stat
);

    logic [DATA_W-1:0] int_masked, err_kept;
    logic [DATA_W-1:0] int_set, err_set;
    logic [DATA_W-1:0] int_next, err_next;

    // Stage one: AND-mask the interrupt register, wipe errors if master clears
    always_comb begin
        int_masked = int_we ? (int_stat & wdata) : int_stat;
        err_kept   = (int_we && !int_masked[INT_MASTER]) ? (err_stat & ~ERR_MASK) : err_stat;
    end

    // Stage two: collect bits raised by completions and unknown commands
    always_comb begin
        int_set = '0;
        err_set = '0;
        if (done_valid) begin
            int_set[INT_MASTER] = 1'b1;
            case (op_kind_e'(done_op))
                OP_RESET: int_set[INT_RST]   = 1'b1;
                OP_ERASE: int_set[INT_ERASE] = 1'b1;
                OP_PROG:  int_set[INT_PROG]  = 1'b1;
                default:  int_set[INT_LOAD]  = 1'b1;
            endcase
            if (done_fail) begin
                err_set[ERR_CMD] = 1'b1;
                case (op_kind_e'(done_op))
                    OP_ERASE: err_set[ERR_ERASE] = 1'b1;
                    OP_PROG:  err_set[ERR_PROG]  = 1'b1;
                    OP_LOAD:  err_set[ERR_LOAD]  = 1'b1;
                    default:  err_set[ERR_CMD]   = 1'b1;
                endcase
            end
        end
        if (unknown_cmd) begin
            int_set[INT_MASTER] = 1'b1;
            err_set[ERR_CMD]    = 1'b1;
        end
        int_next = int_masked | int_set;
        err_next = err_kept | err_set;
    end

    // Register the status pair with cold and warm reset values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_stat <= INT_COLD;
            err_stat <= '0;
        end else if (soft_rst) begin
            int_stat <= INT_WARM;
            err_stat <= '0;
        end else begin
            int_stat <= int_next;
            err_stat <= err_next;
        end
    end

    assert_done_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !soft_rst) |=> int_stat[INT_MASTER]);

    assert_fail_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fail && !soft_rst) |=> err_stat[ERR_CMD]);

    assert_unknown_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (unknown_cmd && !soft_rst) |=> (int_stat[INT_MASTER] && err_stat[ERR_CMD]));

    assert_err_wipe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int_we && !wdata[INT_MASTER] && !done_valid && !unknown_cmd && !soft_rst)
        |=> ((err_stat & ERR_MASK) == '0));

    assert_warm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (int_stat == INT_WARM && err_stat == '0));

endmodule

// File: rtl/flash_ctl_cfg.sv
// Configuration unit: holds both configuration registers, the start-buffer
// fields and the ready pin. Decodes the sector-count code where zero
// means the maximum count. Assumes one write strobe active per cycle.
module flash_ctl_cfg
    import flash_ctl_pkg::*;
#(
    parameter int BUF_W = 4,
    parameter int CNT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              cfg1_we,
    input  logic              cfg2_we,
    input  logic              sbuf_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cfg1,
    output logic [DATA_W-1:0] cfg2,
    output logic [BUF_W-1:0]  buf_sel,
    output logic [CNT_W-1:0]  cnt_raw,
    output logic [CNT_W:0]    sec_count,
    output logic              rdy
);

    localparam int CNT_MAX = 1 << CNT_W;

    // Register configuration, start-buffer fields and ready pin
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            cfg1    <= CFG1_RST;
            cfg2    <= CFG2_RST;
            buf_sel <= '0;
            cnt_raw <= CNT_W'(1);
            rdy     <= 1'b1;
        end else begin
            if (cfg1_we) begin
                cfg1 <= wdata;
                rdy  <= wdata[CFG1_RDY_BIT];
            end
            if (cfg2_we) begin
                cfg2 <= wdata;
            end
            if (sbuf_we) begin
                buf_sel <= wdata[8 +: BUF_W];
                cnt_raw <= wdata[CNT_W-1:0];
            end
        end
    end

    // Expand the count code: zero stands for the largest count
    always_comb begin
        sec_count = (cnt_raw == '0) ? (CNT_W+1)'(CNT_MAX) : {1'b0, cnt_raw};
    end

    assert_rdy_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg1_we && !soft_rst) |=> (rdy == $past(wdata[CFG1_RDY_BIT])));

    assert_count_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_count != '0) && (sec_count <= (CNT_W+1)'(CNT_MAX)));

endmodule

// File: rtl/flash_ctl_core.sv
// Top of the flash controller control core. Decodes register offsets,
// wires the command gate, status unit and configuration unit together,
// and forms the read mux and the polarity-selected interrupt pin.
// Assumes reads are combinational on bus_addr with no side effects.
module flash_ctl_core
    import flash_ctl_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int BUF_W  = 4,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              done_valid,
    input  logic [1:0]        done_op,
    input  logic              done_fail,
    output logic              cmd_start,
    output logic [DATA_W-1:0] cmd_code,
    output logic [BUF_W-1:0]  buf_sel,
    output logic [CNT_W:0]    sec_count,
    output logic              irq,
    output logic              rdy
);

    logic              sel_cmd, sel_cfg1, sel_cfg2, sel_stat, sel_int, sel_sbuf;
    logic [DATA_W-1:0] cmd_q, int_stat, err_stat, cfg1, cfg2;
    logic [CNT_W-1:0]  cnt_raw;
    logic              unknown_cmd, soft_rst;

    // Decode which register the bus addresses
    always_comb begin
        sel_cmd  = (bus_addr == ADDR_W'(OFF_CMD));
        sel_cfg1 = (bus_addr == ADDR_W'(OFF_CFG1));
        sel_cfg2 = (bus_addr == ADDR_W'(OFF_CFG2));
        sel_stat = (bus_addr == ADDR_W'(OFF_STAT));
        sel_int  = (bus_addr == ADDR_W'(OFF_INT));
        sel_sbuf = (bus_addr == ADDR_W'(OFF_SBUF));
    end

    flash_ctl_cmd_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_we      (bus_we && sel_cmd),
        .wdata       (bus_wdata),
        .pending     (int_stat[INT_MASTER]),
        .cmd_q       (cmd_q),
        .cmd_start   (cmd_start),
        .cmd_code    (cmd_code),
        .unknown_cmd (unknown_cmd),
        .soft_rst    (soft_rst)
    );

    flash_ctl_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .unknown_cmd (unknown_cmd),
        .int_we      (bus_we && sel_int),
        .wdata       (bus_wdata),
        .done_valid  (done_valid),
        .done_op     (done_op),
        .done_fail   (done_fail),
        .int_stat    (int_stat),
        .err_stat    (err_stat)
    );

    flash_ctl_cfg #(.BUF_W(BUF_W), .CNT_W(CNT_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .cfg1_we   (bus_we && sel_cfg1),
        .cfg2_we   (bus_we && sel_cfg2),
        .sbuf_we   (bus_we && sel_sbuf),
        .wdata     (bus_wdata),
        .cfg1      (cfg1),
        .cfg2      (cfg2),
        .buf_sel   (buf_sel),
        .cnt_raw   (cnt_raw),
        .sec_count (sec_count),
        .rdy       (rdy)
    );

    // Select read data for the addressed register
    always_comb begin
        bus_rdata = '0;
        if (sel_cmd) begin
            bus_rdata = cmd_q;
        end else if (sel_cfg1) begin
            bus_rdata = cfg1 & CFG1_RDMASK;
        end else if (sel_cfg2) begin
            bus_rdata = cfg2;
        end else if (sel_stat) begin
            bus_rdata = err_stat;
        end else if (sel_int) begin
            bus_rdata = int_stat;
        end else if (sel_sbuf) begin
            bus_rdata[8 +: BUF_W]   = buf_sel;
            bus_rdata[CNT_W-1:0]    = cnt_raw;
        end
    end

    // Interrupt pin: master flag matched against the polarity bit
    always_comb begin
        irq = ~(int_stat[INT_MASTER] ^ cfg1[CFG1_POL_BIT]);
    end

    assert_no_start_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel_cmd && int_stat[INT_MASTER]) |=> (!cmd_start && $stable(err_stat)));

    assert_softrst_nostart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !cmd_start);

endmodule

// File: tb/test_flash_ctl_core.sv
`timescale 1ns/1ps
module test_flash_ctl_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        done_valid = 1'b0;
    logic [1:0]  done_op = '0;
    logic        done_fail = 1'b0;
    logic        cmd_start;
    logic [15:0] cmd_code;
    logic [3:0]  buf_sel;
    logic [2:0]  sec_count;
    logic        irq, rdy;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    flash_ctl_core i_flash_ctl_core (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_valid(done_valid),
        .done_op(done_op), .done_fail(done_fail), .cmd_start(cmd_start),
        .cmd_code(cmd_code), .buf_sel(buf_sel), .sec_count(sec_count),
        .irq(irq), .rdy(rdy)
    );

    // Vector: {we, addr, wdata, done_valid, done_op, done_fail, read addr, expected}
    localparam int NV = 17;
    localparam logic [44:0] VEC [0:NV-1] = '{
        {1'b1, 4'h5, 16'h0000, 1'b0, 2'd0, 1'b0, 4'h5, 16'h0000},
        {1'b1, 4'h0, 16'h0094, 1'b0, 2'd0, 1'b0, 4'h0, 16'h0094},
        {1'b0, 4'h0, 16'h0000, 1'b1, 2'd1, 1'b0, 4'h5, 16'h8020},
        {1'b1, 4'h0, 16'h0080, 1'b0, 2'd0, 1'b0, 4'h0, 16'h0094},
        {1'b1, 4'h5, 16'h7FFF, 1'b0, 2'd0, 1'b0, 4'h5, 16'h0020},
        {1'b1, 4'h0, 16'h0055, 1'b0, 2'd0, 1'b0, 4'h4, 16'h0400},
        {1'b0, 4'h0, 16'h0000, 1'b0, 2'd0, 1'b0, 4'h5, 16'h8020},
        {1'b0, 4'h0, 16'h0000, 1'b1, 2'd3, 1'b1, 4'h4, 16'h2400},
        {1'b0, 4'h0, 16'h0000, 1'b0, 2'd0, 1'b0, 4'h5, 16'h80A0},
        {1'b1, 4'h5, 16'hFFFF, 1'b0, 2'd0, 1'b0, 4'h4, 16'h2400},
        {1'b1, 4'h5, 16'h0000, 1'b0, 2'd0, 1'b0, 4'h4, 16'h0000},
        {1'b1, 4'h1, 16'h00FF, 1'b0, 2'd0, 1'b0, 4'h1, 16'h00E0},
        {1'b1, 4'h2, 16'hABCD, 1'b0, 2'd0, 1'b0, 4'h2, 16'hABCD},
        {1'b1, 4'h8, 16'h0A03, 1'b0, 2'd0, 1'b0, 4'h8, 16'h0A03},
        {1'b1, 4'h8, 16'h0500, 1'b0, 2'd0, 1'b0, 4'h8, 16'h0500},
        {1'b0, 4'h0, 16'h0000, 1'b1, 2'd0, 1'b1, 4'h4, 16'h0400},
        {1'b0, 4'h0, 16'h0000, 1'b0, 2'd0, 1'b0, 4'h5, 16'h8010}
    };
    string vreq [0:NV-1];

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_chk(input string req, input logic [3:0] a, input logic [15:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    // One cycle of bus write and/or done pulse; returns at the following negedge
    task automatic cycle(input logic we, input logic [3:0] a, input logic [15:0] d,
                         input logic dv, input logic [1:0] op, input logic df);
        bus_we = we; bus_addr = a; bus_wdata = d;
        done_valid = dv; done_op = op; done_fail = df;
        @(negedge clk);
        bus_we = 1'b0; done_valid = 1'b0; done_fail = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        cycle(1'b1, a, d, 1'b0, 2'd0, 1'b0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        vreq = '{"R6", "R4", "R7", "R3", "R6", "R5", "R5", "R8", "R7",
                 "R6", "R6", "R11", "R11", "R12", "R12", "R8", "R7"};
        // Cold reset
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        read_chk("R1", 4'h1, 16'h40C0);
        read_chk("R1", 4'h2, 16'h0000);
        read_chk("R1", 4'h4, 16'h0000);
        read_chk("R1", 4'h5, 16'h8080);
        read_chk("R1", 4'h0, 16'h0000);
        read_chk("R1", 4'h8, 16'h0001);
        check("R1", {14'h0, rdy, irq}, 16'h0003);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cycle(VEC[i][44], VEC[i][43:40], VEC[i][39:24], VEC[i][23], VEC[i][22:21], VEC[i][20]);
            read_chk(vreq[i], VEC[i][19:16], VEC[i][15:0]);
        end

        // Start-buffer decode: code 0 means 4 sectors
        check("R12", {9'h0, buf_sel, sec_count}, {9'h0, 4'h5, 3'd4});

        // Ready and interrupt polarity
        @(negedge clk);
        check("R2", {15'h0, irq}, 16'h0001);
        wr(4'h1, 16'h0000);
        check("R11", {15'h0, rdy}, 16'h0000);
        check("R2", {15'h0, irq}, 16'h0000);
        wr(4'h1, 16'h0040);
        check("R2", {15'h0, irq}, 16'h0001);
        wr(4'h5, 16'h0000);
        check("R2", {15'h0, irq}, 16'h0000);

        // Accepted command produces a start pulse with the code
        wr(4'h0, 16'h001B);
        check("R4", {15'h0, cmd_start}, 16'h0001);
        check("R4", cmd_code, 16'h001B);
        @(negedge clk);
        check("R4", {15'h0, cmd_start}, 16'h0000);

        // Same-cycle acknowledge write and failing completion
        cycle(1'b0, 4'h0, 16'h0000, 1'b1, 2'd3, 1'b1);
        read_chk("R8", 4'h4, 16'h2400);
        cycle(1'b1, 4'h5, 16'h0000, 1'b1, 2'd1, 1'b1);
        read_chk("R9", 4'h5, 16'h8020);
        read_chk("R9", 4'h4, 16'h0C00);

        // Command dropped while pending
        wr(4'h0, 16'h0000);
        check("R3", {15'h0, cmd_start}, 16'h0000);
        read_chk("R3", 4'h0, 16'h001B);
        read_chk("R3", 4'h4, 16'h0C00);

        // Warm reset by command after acknowledging
        wr(4'h5, 16'h0000);
        wr(4'h0, 16'h00F3);
        check("R10", {15'h0, cmd_start}, 16'h0000);
        read_chk("R10", 4'h5, 16'h8010);
        read_chk("R10", 4'h1, 16'h40C0);
        read_chk("R10", 4'h2, 16'h0000);
        read_chk("R10", 4'h4, 16'h0000);
        read_chk("R10", 4'h0, 16'h0000);
        read_chk("R10", 4'h8, 16'h0001);
        check("R10", {15'h0, rdy}, 16'h0001);

        // Cold reset after activity
        wr(4'h2, 16'h1234);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        read_chk("R1", 4'h5, 16'h8080);
        read_chk("R1", 4'h2, 16'h0000);

        summary();
    end

endmodule